// File: doc/BRIEF.md
# Double-Buffered Transmit Serializer

This block is the byte-wide transmit path of a simple radio baseband. A host writes bytes into a one-byte holding register through a plain register write port. On request, the byte moves into a shift register and leaves on a single serial line, most significant bit first, one bit for each bit-enable tick. Because the holding register and the shift register are separate stages, the host can queue the next byte while the current one is still being shifted. A byte that is waiting when the current one finishes is sent with no idle gap.

Four events are tracked: a start request with nothing to send, a write that arrives while a byte is still waiting, the moment a waiting byte is taken into the shifter, and the end of the stream. Each event sets a sticky flag. A host-written mask selects which flags drive the single interrupt output. Flags are read from a status register and cleared by writing ones to it.

Top module: `tx_serializer`

## Requirements
- R1: The mask register is at address 0x0D. Its bit 3 enables the underflow interrupt, bit 2 overflow, bit 1 done and bit 0 empty. A 1 enables the interrupt and a 0 disables it. A write stores wdata[3:0].
- R2: A read of address 0x0D returns the stored mask in bits 3:0, with bits 7:4 always zero, whatever value was written to them.
- R3: After synchronous reset the mask and all flags are zero, irq is 0, ser_out is 0 and tx_busy is 0.
- R4: A write to the data address 0x0F is accepted only when the holding register is empty. A write while a byte is waiting sets the overflow flag (bit 2). The written byte is discarded and the waiting byte is later sent unchanged.
- R5: A tx_start pulse while the shifter is idle and the holding register is empty sets the underflow flag (bit 3), and nothing is sent.
- R6: A byte is sent most significant bit first. Each bit stays on ser_out until a bit_tick arrives, and eight ticks send one byte. tx_busy is 1 while a byte is in the shifter. ser_out is 0 while idle.
- R7: The empty flag (bit 0) is set on the edge where the waiting byte moves into the shift register.
- R8: On the tick that completes the last bit, if no byte is waiting, the done flag (bit 1) is set and tx_busy falls.
- R9: irq is the OR, over the four flags, of each flag ANDed with its mask bit. A flag that is masked does not raise irq.
- R10: A byte that is waiting when the last bit of the current byte completes is loaded on that same edge. Two queued bytes therefore take exactly 16 ticks of busy time.
- R11: A read of address 0x0E returns the flags in the same bit positions as the mask. Writing 1 to a bit clears that flag. An event in the same cycle wins over the clear.
- R12: tx_start while busy has no effect and does not flag underflow. bit_tick while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | Bit-enable pulse; advances the shifter by one bit |
| tx_start | input | 1 | Request to begin transmission |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| ser_out | output | 1 | Serial data, MSB first |
| tx_busy | output | 1 | A byte is in the shift register |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench targets the following corner cases:

- **Write into an occupied holding register.** A design that overwrites the waiting byte instead of dropping the new one sends the wrong data.
- **Hand-off between back-to-back bytes.** A design that idles for a cycle before loading the next byte shows a gap in tx_busy and a wrong bit stream.
- **Start requests in the wrong state.** A start while already busy must not raise a spurious underflow. A start with an empty holding register must not begin a transmission.
- **Mask behaviour.** Flags gated by the wrong mask bit, or reserved mask bits that read back non-zero, show up on irq or rdata.
- **Event against clear.** An event in the same cycle as a clear of that flag must leave the flag set.

A behavioural model with a queue is compared against the design on every clock, including a long run with random ticks and writes.

// File: rtl/txs_pkg.sv
package txs_pkg;

    localparam int REG_ADDR_W = 8;

    localparam logic [REG_ADDR_W-1:0] ADDR_MASK = 8'h0D;
    localparam logic [REG_ADDR_W-1:0] ADDR_STAT = 8'h0E;
    localparam logic [REG_ADDR_W-1:0] ADDR_DATA = 8'h0F;

    localparam int COND_N = 4;

    // Packed order fixes bit positions: underrun=3, overrun=2, drained=1, vacated=0
    typedef struct packed {
        logic underrun;
        logic overrun;
        logic drained;
        logic vacated;
    } txs_cond_t;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_SEND = 1'b1
    } sh_state_t;

    function automatic logic [COND_N-1:0] cond_bits(input txs_cond_t c);
        return {c.underrun, c.overrun, c.drained, c.vacated};
    endfunction

    function automatic txs_cond_t cond_merge(input txs_cond_t a, input txs_cond_t b);
        txs_cond_t r;
        r.underrun = a.underrun | b.underrun;
        r.overrun  = a.overrun  | b.overrun;
        r.drained  = a.drained  | b.drained;
        r.vacated  = a.vacated  | b.vacated;
        return r;
    endfunction

endpackage

// File: rtl/txs_holding.sv
module txs_holding
    import txs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          take,
    output logic          valid,
    output logic [DW-1:0] data,
    output txs_cond_t     ev
);

    logic accept;

    // A write lands only when the stage was empty at the start of the cycle
    assign accept = wr && !valid;

    always_comb begin
        ev         = '0;
        ev.overrun = wr && valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            if (take) begin
                valid <= 1'b0;
            end
            if (accept) begin
                valid <= 1'b1;
                data  <= wdata;
            end
        end
    end

    AST_OVF_KEEP: assert property (@(posedge clk) disable iff (rst)
        (valid && wr && !take) |=> (valid && data == $past(data))); // R4

    AST_TAKE_FULL: assert property (@(posedge clk) disable iff (rst)
        take |-> valid); // R7

endmodule

// File: rtl/txs_shifter.sv
module txs_shifter
    import txs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          tick,
    input  logic          hold_valid,
    input  logic [DW-1:0] hold_data,
    output logic          take,
    output logic          busy,
    output logic          ser_out,
    output txs_cond_t     ev
);

    localparam int CW = $clog2(DW + 1);

    sh_state_t     st;
    logic [DW-1:0] sh;
    logic [CW-1:0] left;
    logic          last;

    assign last    = (left == CW'(1));
    assign busy    = (st == SH_SEND);
    assign ser_out = busy & sh[DW-1];

    always_comb begin
        take = 1'b0;
        ev   = '0;
        if (st == SH_IDLE) begin
            if (start) begin
                if (hold_valid) begin
                    take       = 1'b1;
                    ev.vacated = 1'b1;
                end else begin
                    ev.underrun = 1'b1;
                end
            end
        end else if (tick && last) begin
            if (hold_valid) begin
                take       = 1'b1;
                ev.vacated = 1'b1;
            end else begin
                ev.drained = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SH_IDLE;
            sh   <= '0;
            left <= '0;
        end else if (take) begin
            st   <= SH_SEND;
            sh   <= hold_data;
            left <= CW'(DW);
        end else if (st == SH_SEND && tick) begin
            if (last) begin
                st   <= SH_IDLE;
                left <= '0;
            end else begin
                sh   <= {sh[DW-2:0], 1'b0};
                left <= left - CW'(1);
            end
        end
    end

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> (busy && $stable(ser_out))); // R6

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy); // R12

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        ev.drained |=> !busy); // R8

    AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
        (busy && tick && last && hold_valid) |=> busy); // R10

endmodule

// File: rtl/txs_irq.sv
module txs_irq
    import txs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_wr,
    input  logic [COND_N-1:0] mask_in,
    input  logic              clr_wr,
    input  logic [COND_N-1:0] clr_bits,
    input  txs_cond_t         ev,
    output logic [COND_N-1:0] mask,
    output logic [COND_N-1:0] flags,
    output logic              irq
);

    logic [COND_N-1:0] ev_bits;
    logic [COND_N-1:0] clr_eff;

    assign ev_bits = cond_bits(ev);
    assign clr_eff = clr_wr ? clr_bits : '0;
    assign irq     = |(flags & mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask  <= '0;
            flags <= '0;
        end else begin
            if (mask_wr) begin
                mask <= mask_in;
            end
            flags <= (flags & ~clr_eff) | ev_bits;
        end
    end

    for (genvar i = 0; i < COND_N; i++) begin : g_flag_chk
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            (flags[i] && !clr_eff[i]) |=> flags[i]); // R11
        AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
            ev_bits[i] |=> flags[i]); // R11
    end

endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
    import txs_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = REG_ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_tick,
    input  logic          tx_start,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          ser_out,
    output logic          tx_busy,
    output logic          irq
);

    logic              sel_mask;
    logic              sel_stat;
    logic              sel_data;
    logic              hold_valid;
    logic [DW-1:0]     hold_data;
    logic              take;
    txs_cond_t         ev_hold;
    txs_cond_t         ev_shift;
    txs_cond_t         ev_all;
    logic [COND_N-1:0] mask;
    logic [COND_N-1:0] flags;

    assign sel_mask = (addr == AW'(ADDR_MASK));
    assign sel_stat = (addr == AW'(ADDR_STAT));
    assign sel_data = (addr == AW'(ADDR_DATA));
    assign ev_all   = cond_merge(ev_hold, ev_shift);

    txs_holding #(.DW(DW)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_en && sel_data),
        .wdata (wdata),
        .take  (take),
        .valid (hold_valid),
        .data  (hold_data),
        .ev    (ev_hold)
    );

    txs_shifter #(.DW(DW)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .start      (tx_start),
        .tick       (bit_tick),
        .hold_valid (hold_valid),
        .hold_data  (hold_data),
        .take       (take),
        .busy       (tx_busy),
        .ser_out    (ser_out),
        .ev         (ev_shift)
    );

    txs_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .mask_wr  (wr_en && sel_mask),
        .mask_in  (wdata[COND_N-1:0]),
        .clr_wr   (wr_en && sel_stat),
        .clr_bits (wdata[COND_N-1:0]),
        .ev       (ev_all),
        .mask     (mask),
        .flags    (flags),
        .irq      (irq)
    );

    always_comb begin
        rdata = '0;
        if (sel_mask) begin
            rdata[COND_N-1:0] = mask;
        end else if (sel_stat) begin
            rdata[COND_N-1:0] = flags;
        end
    end

    AST_UNDERFLOW_NO_SEND: assert property (@(posedge clk) disable iff (rst)
        (tx_start && !tx_busy && !hold_valid) |=> !tx_busy); // R5

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq); // R9

endmodule

// File: tb/tx_serializer_test.sv
module tx_serializer_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_MASK = 8'h0D;
    localparam logic [7:0] A_STAT = 8'h0E;
    localparam logic [7:0] A_DATA = 8'h0F;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       tx_start = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ser_out;
    logic       tx_busy;
    logic       irq;

    int vectors = 0;
    int misses  = 0;

    int tick_div = 1;   // 0 = random ticks, n = one tick every n cycles
    bit tick_on  = 1'b1;
    int tick_cnt = 0;

    int       hq[$];
    bit       m_act;
    int       m_cur;
    int       m_left;
    bit [3:0] m_flags;
    bit [3:0] m_mask;
    bit [3:0] m_ev;
    bit       m_hv;

    tx_serializer uut (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (bit_tick),
        .tx_start (tx_start),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .ser_out  (ser_out),
        .tx_busy  (tx_busy),
        .irq      (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    // Tick generator, driven after the edge
    always @(posedge clk) begin
        #1;
        if (!tick_on) bit_tick = 1'b0;
        else if (tick_div == 0) bit_tick = 1'($urandom % 2);
        else bit_tick = ((tick_cnt % tick_div) == 0);
        tick_cnt++;
    end

    // Behavioural reference model
    always @(posedge clk) begin
        m_ev = 4'b0;
        m_hv = (hq.size() > 0);
        if (rst) begin
            hq.delete();
            m_act = 1'b0; m_cur = 0; m_left = 0; m_flags = 4'b0; m_mask = 4'b0;
        end else begin
            if (!m_act) begin
                if (tx_start) begin
                    if (m_hv) begin
                        m_cur = hq.pop_front(); m_left = 8; m_act = 1'b1; m_ev[0] = 1'b1;
                    end else m_ev[3] = 1'b1;
                end
            end else if (bit_tick) begin
                m_left--;
                if (m_left == 0) begin
                    if (m_hv) begin
                        m_cur = hq.pop_front(); m_left = 8; m_ev[0] = 1'b1;
                    end else begin
                        m_act = 1'b0; m_ev[1] = 1'b1;
                    end
                end
            end
            if (wr_en && addr == A_DATA) begin
                if (m_hv) m_ev[2] = 1'b1;
                else hq.push_back(int'(wdata));
            end
            if (wr_en && addr == A_MASK) m_mask = wdata[3:0];
            if (wr_en && addr == A_STAT) m_flags = m_flags & ~wdata[3:0];
            m_flags = m_flags | m_ev;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            int exp_rd;
            int exp_ser;
            exp_ser = m_act ? ((m_cur >> (m_left - 1)) & 1) : 0;
            exp_rd  = (addr == A_MASK) ? int'(m_mask) : (addr == A_STAT) ? int'(m_flags) : 0;
            chk("R6", "ser_out", int'(ser_out), exp_ser);
            chk("R6", "tx_busy", int'(tx_busy), int'(m_act));
            chk("R9", "irq", int'(irq), int'(|(m_flags & m_mask)));
            chk("R2/R11", "rdata", int'(rdata), exp_rd);
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic start_pulse();
        @(posedge clk); #1;
        tx_start = 1'b1;
        @(posedge clk); #1;
        tx_start = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input int exp);
        @(posedge clk); #1;
        addr = a;
        #3;
        chk(req, "register read", int'(rdata), exp);
    endtask

    task automatic wait_idle();
        int guard = 0;
        while ((tx_busy || m_act) && guard < 2000) begin
            @(posedge clk); #1; guard++;
        end
    endtask

    task automatic send_capture(output logic [7:0] got);
        logic [7:0] acc = 8'h00;
        fork
            start_pulse();
            begin
                @(posedge tx_busy);
                for (int i = 0; i < 8; i++) begin
                    @(negedge clk);
                    acc = {acc[6:0], ser_out};
                end
            end
        join
        got = acc;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        misses++;
        $display("FAIL watchdog: actual running expected finished");
        report();
        $finish;
    end

    initial begin
        logic [7:0] got;
        int busy_cnt;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R3: reset state
        rd_chk("R3", A_MASK, 0);
        rd_chk("R3", A_STAT, 0);
        chk("R3", "irq after reset", int'(irq), 0);
        chk("R3", "ser_out after reset", int'(ser_out), 0);
        chk("R3", "tx_busy after reset", int'(tx_busy), 0);

        // R1/R2: mask stores low nibble, reserved bits read zero
        wr(A_MASK, 8'hFF);
        rd_chk("R2", A_MASK, 8'h0F);
        wr(A_MASK, 8'hA6);
        rd_chk("R1", A_MASK, 8'h06);

        // R5/R9: underflow with its enable off, then on
        tick_div = 1;
        start_pulse();
        rd_chk("R5", A_STAT, 8'h08);
        chk("R9", "masked underflow irq", int'(irq), 0);
        wr(A_MASK, 8'h08);
        idle(1);
        chk("R9", "enabled underflow irq", int'(irq), 1);

        // R11: write-one clear
        wr(A_STAT, 8'h08);
        rd_chk("R11", A_STAT, 0);
        chk("R11", "irq after clear", int'(irq), 0);

        // R6/R7/R8: single byte, MSB first
        wr(A_MASK, 8'h0F);
        wr(A_DATA, 8'hA5);
        send_capture(got);
        chk("R6", "serial byte", int'(got), 8'hA5);
        wait_idle();
        rd_chk("R7", A_STAT, 8'h03);
        chk("R8", "busy after done", int'(tx_busy), 0);
        wr(A_STAT, 8'h0F);

        // R4: overflow keeps the waiting byte
        wr(A_DATA, 8'h11);
        wr(A_DATA, 8'h22);
        rd_chk("R4", A_STAT, 8'h04);
        send_capture(got);
        chk("R4", "kept byte", int'(got), 8'h11);
        wait_idle();
        wr(A_STAT, 8'h0F);

        // R10: back-to-back bytes, no gap
        wr(A_DATA, 8'h3C);
        busy_cnt = 0;
        fork
            begin start_pulse(); wr(A_DATA, 8'hC3); end
            begin
                @(posedge tx_busy);
                while (tx_busy) begin
                    @(negedge clk);
                    if (tx_busy) busy_cnt++;
                end
            end
        join
        chk("R10", "busy cycles for two bytes", busy_cnt, 16);
        wait_idle();
        wr(A_STAT, 8'h0F);

        // R12: start while busy ignored; ticks while idle ignored
        tick_div = 3;
        wr(A_DATA, 8'h5A);
        start_pulse();
        idle(4);
        start_pulse();
        wait_idle();
        rd_chk("R12", A_STAT, 8'h03);
        wr(A_STAT, 8'h0F);
        wr(A_DATA, 8'h77);
        tick_div = 1;
        idle(20);
        chk("R12", "busy with idle ticks", int'(tx_busy), 0);
        chk("R12", "ser_out with idle ticks", int'(ser_out), 0);
        send_capture(got);
        chk("R12", "byte after idle ticks", int'(got), 8'h77);
        wait_idle();

        // R11: event and clear in the same cycle, event wins
        wr(A_STAT, 8'h0F);
        @(posedge clk); #1;
        tx_start = 1'b1; wr_en = 1'b1; addr = A_STAT; wdata = 8'h08;
        @(posedge clk); #1;
        tx_start = 1'b0; wr_en = 1'b0;
        rd_chk("R11", A_STAT, 8'h08);

        // Random traffic, model compared every cycle
        tick_div = 0;
        for (int n = 0; n < 3000; n++) begin
            @(posedge clk); #1;
            wr_en    = (($urandom % 4) == 0);
            case ($urandom % 4)
                0: addr = A_MASK;
                1: addr = A_STAT;
                default: addr = A_DATA;
            endcase
            wdata    = 8'($urandom);
            tx_start = (($urandom % 6) == 0);
        end
        @(posedge clk); #1;
        wr_en = 1'b0; tx_start = 1'b0;
        idle(40);

        report();
        $finish;
    end

endmodule